// File: doc/BRIEF.md
# Serial Frame Recognizer with Exception Handling

This block watches a single serial data line, one bit per clock, and recognizes short fixed-length frames. After reset it hunts for a leading 1 marker. Once that marker is seen it parses frames of four bits back to back. Exactly two bit patterns count as good transmissions. Every other pattern takes an error-recovery path that restarts parsing at the next frame boundary. A one-cycle pulse reports each completed frame as good or bad.

Three interrupt lines (system, user, timeout) can abort the frame being parsed. An interrupt is honoured only at the frame level and never while hunting. It stops parsing in the cycle it is seen and runs a fixed two-cycle handler. During the handler `busy` is high and a handler code is shown. Control never goes back to the aborted position: once the handler ends, a new frame starts. A sync input holds back the first bit of each frame until it is high.

Reset returns the whole machine to the hunting state. It is synchronous by default, and a parameter selects an asynchronous reset instead.

Top module: `sfr_top`

## Requirements
- R1: While `rst` is high at a clock edge, every register is cleared. After that edge `frameOk`, `frameErr` and `busy` are 0, `handlerId` is 0, and the machine is hunting for a leading 1.
- R2: After the leading 1, the frame level collects 4 bits, with the first received bit as the most significant. The words 4'b1100 (bits 1,1,0,0) and 4'b0011 (bits 0,0,1,1) raise `frameOk` for exactly one cycle. That cycle is the one right after the clock edge that samples the fourth bit.
- R3: Any other 4-bit word raises `frameErr` for one cycle, with the same timing as R2. The next bit consumed is then the first bit of a new frame; no new leading 1 is needed.
- R4: While hunting, 0 bits are discarded and all interrupt inputs are ignored: `busy` stays 0.
- R5: The first bit of a frame is consumed only in a cycle where `syncIn` is 1. The second to fourth bits are consumed whatever `syncIn` is.
- R6: At the frame level, an interrupt input at 1 aborts the frame in that same cycle. The bit presented in that cycle is dropped, and the aborted frame produces neither pulse. `busy` is then high for exactly 2 cycles, starting in the next cycle.
- R7: Simultaneous interrupts are served in the order system, user, timeout. `handlerId` shows 1 for system, 2 for user and 3 for timeout while `busy` is high, and 0 otherwise.
- R8: Interrupts raised while a handler runs are ignored, and `handlerId` holds its value. When the handler ends, parsing resumes at the start of a new frame: it is gated by `syncIn`, and no leading 1 is needed.
- R9: `frameOk` and `frameErr` are never high together, and neither is high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Top-level reset, active high (synchronous unless ASYNC_RST=1) |
| syncIn | input | 1 | Sync condition gating the first bit of each frame |
| bitIn | input | 1 | Serial data bit, sampled every clock |
| intSys | input | 1 | System interrupt request (highest priority) |
| intUsr | input | 1 | User interrupt request |
| intTmo | input | 1 | Timeout interrupt request (lowest priority) |
| frameOk | output | 1 | One-cycle pulse: good frame received |
| frameErr | output | 1 | One-cycle pulse: bad frame received |
| handlerId | output | 2 | Active handler code: 1 system, 2 user, 3 timeout, 0 idle |
| busy | output | 1 | High while an interrupt handler runs |

## Verification
A wrong bit counter or shift register shows up at the first completed frame, within four consumed bits: the pulse comes one cycle early or late, or good and bad are swapped. A wrong phase register shows up within one or two cycles as a difference on `busy`. Examples are an interrupt accepted while hunting, a handler that is re-entered, or a frame that resumes after an abort. A wrong priority selection shows up on `handlerId` in the first cycle of the handler. Because the reference model is compared on every clock, each of these faults is reported in the cycle it first reaches a port.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [1:0] {
    S_HUNT  = 2'd0,
    S_FRAME = 2'd1,
    S_HND   = 2'd2
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic take;     // consume bitIn into the frame word
    logic restart;  // clear the frame bit counter
    logic hndClr;   // clear the handler cycle counter
    logic hndInc;   // advance the handler cycle counter
  } strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic atStart;  // no bit of the current frame consumed yet
    logic lastBit;  // the next consumed bit completes the frame
    logic wordGood; // frame word including bitIn matches a good pattern
    logic hndLast;  // handler is in its final cycle
  } status_t;

  typedef struct packed {
    phase_e     phase;
    logic [1:0] hid;
    logic       ok;
    logic       err;
  } ctrl_reg_t;

  localparam ctrl_reg_t CTRL_RST = '{phase: S_HUNT, hid: 2'd0, ok: 1'b0, err: 1'b0};

  localparam logic [1:0] HID_SYS = 2'd1;
  localparam logic [1:0] HID_USR = 2'd2;
  localparam logic [1:0] HID_TMO = 2'd3;

endpackage

// File: rtl/sfr_dpath.sv
module sfr_dpath
  import sfr_pkg::*;
#(
  parameter bit ASYNC_RST = 1'b0,
  parameter int FRAME_LEN = 4,
  parameter int HND_LEN   = 2,
  parameter logic [FRAME_LEN-1:0] PAT_A = 4'b1100,
  parameter logic [FRAME_LEN-1:0] PAT_B = 4'b0011
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    bitIn,
  input  strobe_t stb,
  output status_t st
);
  localparam int SW = FRAME_LEN - 1;
  localparam int CW = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
  localparam int HW = (HND_LEN > 1) ? $clog2(HND_LEN) : 1;

  logic [SW-1:0] shReg, shRegNx;
  logic [CW-1:0] bitCnt, bitCntNx;
  logic [HW-1:0] hndCnt, hndCntNx;
  logic [FRAME_LEN-1:0] word;

  assign word = {shReg, bitIn};

  always_comb begin
    shRegNx  = stb.take ? SW'({shReg, bitIn}) : shReg;
    bitCntNx = bitCnt;
    if (stb.restart)   bitCntNx = '0;
    else if (stb.take) bitCntNx = bitCnt + CW'(1);
    hndCntNx = hndCnt;
    if (stb.hndClr)      hndCntNx = '0;
    else if (stb.hndInc) hndCntNx = hndCnt + HW'(1);
  end

  assign st.atStart  = (bitCnt == '0);
  assign st.lastBit  = (bitCnt == CW'(FRAME_LEN - 1));
  assign st.wordGood = (word == PAT_A) || (word == PAT_B);
  assign st.hndLast  = (hndCnt == HW'(HND_LEN - 1));

  generate
    if (ASYNC_RST) begin : g_arst
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          shReg  <= '0;
          bitCnt <= '0;
          hndCnt <= '0;
        end else begin
          shReg  <= shRegNx;
          bitCnt <= bitCntNx;
          hndCnt <= hndCntNx;
        end
      end
    end else begin : g_srst
      always_ff @(posedge clk) begin
        if (rst) begin
          shReg  <= '0;
          bitCnt <= '0;
          hndCnt <= '0;
        end else begin
          shReg  <= shRegNx;
          bitCnt <= bitCntNx;
          hndCnt <= hndCntNx;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter bit ASYNC_RST = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bitIn,
  input  logic       syncIn,
  input  logic       intSys,
  input  logic       intUsr,
  input  logic       intTmo,
  input  status_t    st,
  output strobe_t    stb,
  output logic       frameOk,
  output logic       frameErr,
  output logic [1:0] handlerId,
  output logic       busy
);
  ctrl_reg_t cur, nx;
  logic anyInt;
  logic [1:0] pick;

  assign anyInt = intSys | intUsr | intTmo;
  assign pick   = intSys ? HID_SYS : (intUsr ? HID_USR : HID_TMO);

  always_comb begin
    nx     = cur;
    nx.ok  = 1'b0;
    nx.err = 1'b0;
    stb    = '0;
    unique case (cur.phase)
      S_HUNT: begin
        if (bitIn) begin
          nx.phase    = S_FRAME;
          stb.restart = 1'b1;
        end
      end
      S_FRAME: begin
        if (anyInt) begin
          nx.phase    = S_HND;
          nx.hid      = pick;
          stb.restart = 1'b1;
          stb.hndClr  = 1'b1;
        end else if (syncIn || !st.atStart) begin
          stb.take = 1'b1;
          if (st.lastBit) begin
            stb.restart = 1'b1;
            nx.ok       = st.wordGood;
            nx.err      = !st.wordGood;
          end
        end
      end
      S_HND: begin
        if (st.hndLast) begin
          nx.phase = S_FRAME;
          nx.hid   = 2'd0;
        end else begin
          stb.hndInc = 1'b1;
        end
      end
      default: nx = CTRL_RST;
    endcase
  end

  generate
    if (ASYNC_RST) begin : g_arst
      always_ff @(posedge clk or posedge rst) begin
        if (rst) cur <= CTRL_RST;
        else     cur <= nx;
      end
    end else begin : g_srst
      always_ff @(posedge clk) begin
        if (rst) cur <= CTRL_RST;
        else     cur <= nx;
      end
    end
  endgenerate

  assign frameOk   = cur.ok;
  assign frameErr  = cur.err;
  assign handlerId = cur.hid;
  assign busy      = (cur.phase == S_HND);

endmodule

// File: rtl/sfr_top.sv
module sfr_top
  import sfr_pkg::*;
#(
  parameter bit ASYNC_RST = 1'b0,
  parameter int FRAME_LEN = 4,
  parameter int HND_LEN   = 2,
  parameter logic [FRAME_LEN-1:0] PAT_A = 4'b1100,
  parameter logic [FRAME_LEN-1:0] PAT_B = 4'b0011
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       syncIn,
  input  logic       bitIn,
  input  logic       intSys,
  input  logic       intUsr,
  input  logic       intTmo,
  output logic       frameOk,
  output logic       frameErr,
  output logic [1:0] handlerId,
  output logic       busy
);
  strobe_t stb;
  status_t st;

  sfr_dpath #(
    .ASYNC_RST(ASYNC_RST),
    .FRAME_LEN(FRAME_LEN),
    .HND_LEN  (HND_LEN),
    .PAT_A    (PAT_A),
    .PAT_B    (PAT_B)
  ) u_dpath (
    .clk  (clk),
    .rst  (rst),
    .bitIn(bitIn),
    .stb  (stb),
    .st   (st)
  );

  sfr_ctrl #(
    .ASYNC_RST(ASYNC_RST)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bitIn    (bitIn),
    .syncIn   (syncIn),
    .intSys   (intSys),
    .intUsr   (intUsr),
    .intTmo   (intTmo),
    .st       (st),
    .stb      (stb),
    .frameOk  (frameOk),
    .frameErr (frameErr),
    .handlerId(handlerId),
    .busy     (busy)
  );

endmodule

// File: rtl/sfr_chk.sv
module sfr_chk #(
  parameter int HND_LEN = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       intSys,
  input logic       intUsr,
  input logic       intTmo,
  input logic       frameOk,
  input logic       frameErr,
  input logic [1:0] handlerId,
  input logic       busy
);
  localparam int RW = $clog2(HND_LEN + 1) + 1;
  logic [RW-1:0] runLen;

  always_ff @(posedge clk) begin
    if (rst)       runLen <= '0;
    else if (busy) runLen <= runLen + RW'(1);
    else           runLen <= '0;
  end

  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (!frameOk && !frameErr && !busy && handlerId == 2'd0));

  // R2
  ok_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frameOk |=> !frameOk);

  // R3
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frameErr |=> !frameErr);

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (runLen < RW'(HND_LEN)));

  // R6
  busy_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> ($past(runLen) == RW'(HND_LEN - 1)));

  // R7
  sys_first_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && $past(intSys)) |-> (handlerId == 2'd1));

  // R7
  id_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (busy == (handlerId != 2'd0)));

  // R8
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(handlerId));

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(frameOk && frameErr) && !(busy && (frameOk || frameErr)));

endmodule

bind sfr_top sfr_chk #(.HND_LEN(HND_LEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .intSys   (intSys),
  .intUsr   (intUsr),
  .intTmo   (intTmo),
  .frameOk  (frameOk),
  .frameErr (frameErr),
  .handlerId(handlerId),
  .busy     (busy)
);

// File: tb/tb_sfr_top.sv
`timescale 1ns/1ps
module tb_sfr_top;
  logic clk = 1'b0;
  logic rst, syncIn, bitIn, intSys, intUsr, intTmo;
  logic frameOk, frameErr, busy;
  logic [1:0] handlerId;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  // reference model state
  int mPhase = 0;       // 0 hunt, 1 frame, 2 handler
  int mBits[$];
  int mHnd = 0;
  int expOk = 0, expErr = 0, expId = 0, expBusy = 0;

  always #10 clk = ~clk;  // 50 MHz

  sfr_top dut (
    .clk(clk), .rst(rst), .syncIn(syncIn), .bitIn(bitIn),
    .intSys(intSys), .intUsr(intUsr), .intTmo(intTmo),
    .frameOk(frameOk), .frameErr(frameErr), .handlerId(handlerId), .busy(busy)
  );

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    nTests++;
    if (!good) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input int b, input int s, input int sy, input int us, input int tm, input int r);
    expOk = 0;
    expErr = 0;
    if (r != 0) begin
      mPhase = 0; mBits.delete(); mHnd = 0; expId = 0;
    end else if (mPhase == 0) begin
      if (b != 0) begin mPhase = 1; mBits.delete(); end
    end else if (mPhase == 1) begin
      if (sy != 0 || us != 0 || tm != 0) begin
        expId = (sy != 0) ? 1 : ((us != 0) ? 2 : 3);
        mPhase = 2; mHnd = 0; mBits.delete();
      end else if (s != 0 || mBits.size() > 0) begin
        mBits.push_back(b);
        if (mBits.size() == 4) begin
          int w = 0;
          foreach (mBits[i]) w = w * 2 + mBits[i];
          if (w == 12 || w == 3) expOk = 1; else expErr = 1;
          mBits.delete();
        end
      end
    end else begin
      mHnd++;
      if (mHnd == 2) begin mPhase = 1; expId = 0; end
    end
    expBusy = (mPhase == 2) ? 1 : 0;
  endtask

  // drive one cycle, then compare at the following negedge
  task automatic step(input int b, input int s = 1, input int sy = 0, input int us = 0,
                      input int tm = 0, input int r = 0);
    bitIn = b[0]; syncIn = s[0]; intSys = sy[0]; intUsr = us[0]; intTmo = tm[0]; rst = r[0];
    model(b, s, sy, us, tm, r);
    @(posedge clk);
    @(negedge clk);
    chk(frameOk == expOk[0], "R2 frameOk", frameOk, expOk);
    chk(frameErr == expErr[0], "R3 frameErr", frameErr, expErr);
    chk(busy == expBusy[0], "R6 busy", busy, expBusy);
    chk(handlerId == expId[1:0], "R7 handlerId", handlerId, expId);
    chk(!(frameOk && frameErr) && !(busy && (frameOk || frameErr)), "R9 exclusive",
        {frameOk, frameErr, busy}, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; syncIn = 1'b0; bitIn = 1'b0; intSys = 1'b0; intUsr = 1'b0; intTmo = 1'b0;
    @(negedge clk);
    step(0, 0, 0, 0, 0, 1);
    step(1, 1, 1, 1, 1, 1);
    // R1 reset state
    chk(!frameOk && !frameErr && !busy && handlerId == 2'd0, "R1 reset outputs",
        {frameOk, frameErr, busy, handlerId}, 0);

    // R4 hunting ignores zeros and interrupts
    step(0, 1, 1, 0, 0);
    step(0, 1, 0, 1, 1);
    chk(busy == 1'b0, "R4 no interrupt while hunting", busy, 0);

    // leading 1 then good frame 1,1,0,0
    step(1);
    step(1); step(1); step(0); step(0);
    chk(frameOk == 1'b1, "R2 good 1100", frameOk, 1);
    // good frame 0,0,1,1 with no new marker
    step(0); step(0); step(1); step(1);
    chk(frameOk == 1'b1, "R2 good 0011", frameOk, 1);
    // bad frame 0,0,1,0 then immediate new frame 1,1,0,0
    step(0); step(0); step(1); step(0);
    chk(frameErr == 1'b1 && frameOk == 1'b0, "R3 bad 0010", frameErr, 1);
    step(1); step(1); step(0); step(0);
    chk(frameOk == 1'b1, "R3 restart at frame boundary", frameOk, 1);

    // R5 first bit held back while syncIn low
    step(1, 0); step(1, 0);
    step(0, 1); step(0, 0); step(1, 0); step(1, 0);
    chk(frameOk == 1'b1, "R5 sync gates only first bit", frameOk, 1);

    // R6 abort mid-frame with user interrupt
    step(1); step(1);
    step(0, 1, 0, 1, 0);
    chk(busy == 1'b1 && handlerId == 2'd2, "R6 user abort", {busy, handlerId}, 6);
    // R8 interrupt during handler ignored
    step(0, 1, 1, 0, 0);
    chk(busy == 1'b1 && handlerId == 2'd2, "R8 id held in handler", handlerId, 2);
    step(0);
    chk(busy == 1'b0 && frameOk == 1'b0 && frameErr == 1'b0, "R6 two-cycle handler, no pulse",
        {busy, frameOk, frameErr}, 0);
    // R8 resume at new frame without marker, gated by sync
    step(1, 0);
    step(0); step(0); step(1); step(1);
    chk(frameOk == 1'b1, "R8 resume at frame start", frameOk, 1);

    // R7 priority
    step(1, 1, 1, 1, 1);
    chk(handlerId == 2'd1, "R7 system first", handlerId, 1);
    step(0); step(0);
    step(1, 1, 0, 1, 1);
    chk(handlerId == 2'd2, "R7 user over timeout", handlerId, 2);
    step(0); step(0);
    step(1, 1, 0, 0, 1);
    chk(handlerId == 2'd3, "R7 timeout code", handlerId, 3);
    step(0); step(0);

    // randomized streams with injected interrupts and resets
    for (int i = 0; i < 20000; i++) begin
      int r = ($urandom_range(0, 499) == 0) ? 1 : 0;
      step($urandom_range(0, 1),
           ($urandom_range(0, 3) != 0) ? 1 : 0,
           ($urandom_range(0, 59) == 0) ? 1 : 0,
           ($urandom_range(0, 49) == 0) ? 1 : 0,
           ($urandom_range(0, 39) == 0) ? 1 : 0,
           r);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule